// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

A purely combinational 32-bit operand shifter for an ALU or address datapath. It takes a data word, a 3-bit shift-kind code, an 8-bit shift distance and the current carry flag. In the same cycle it returns the shifted word and the carry bit that a flag-setting operation would capture. Five kinds are supported: left logical, right logical, right arithmetic, rotate right, and a one-place rotate through the carry flag.

The carry rules at the awkward distances are exact. A distance of zero leaves the carry untouched. A distance equal to the word width takes its carry from a particular edge bit. A distance beyond the width saturates. All shift kinds share one logarithmic rotator and one fill mask. The kind code decides how the rotated word is masked and where the carry is taken from. There is no state, so the block has no state register; the kind code plays the role of a selector over five fixed "modes": LEFT, RIGHT, ARITH, ROTATE and EXTEND, plus a reserved group.

Top module: `bshf_top`

## Requirements
- R1: The shift-kind code is decoded as 0 = left logical, 1 = right logical, 2 = right arithmetic, 3 = rotate right, 4 = rotate through carry. The codes 5, 6 and 7 are reserved: the result equals the operand and the carry-out equals the carry-in.
- R2: For codes 0 to 3 with a distance of 0, the result equals the operand and the carry-out equals the carry-in.
- R3: For a left logical shift by n, 1 ≤ n ≤ 32, the result is the operand shifted left by n with zeros entering. The carry-out is operand bit 32−n, so n = 32 gives bit 0.
- R4: For a right logical shift by n, 1 ≤ n ≤ 32, the result is the operand shifted right by n with zeros entering. The carry-out is operand bit n−1.
- R5: For a right arithmetic shift by n, 1 ≤ n ≤ 32, the top n result bits copy operand bit 31 and the rest is the operand shifted right by n. The carry-out is operand bit n−1.
- R6: For a right arithmetic shift by more than 32, every result bit and the carry-out equal operand bit 31.
- R7: For a rotate right by a nonzero n, the word is rotated by n mod 32 and the carry-out equals result bit 31. A nonzero multiple of 32 therefore returns the operand, with carry-out equal to operand bit 31.
- R8: For a left or right logical shift by more than 32, the result is zero and the carry-out is zero.
- R9: For rotate through carry, the result is the operand shifted right by one, with the carry-in placed in bit 31. The carry-out is the old operand bit 0. The distance input has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 32 | Operand word |
| shift_kind | input | 3 | Shift-kind code (see R1) |
| shift_dist | input | 8 | Shift distance, 0 to 255 |
| carry_in | input | 1 | Current carry flag |
| data_out | output | 32 | Shifted result |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The result path and the carry path are both settled in the same evaluation. They switch source together at the distance edges 0, 1, 31, 32 and 33, so a fault in one path can hide behind a correct value on the other. The bench drives each kind across those edges with operands whose bit 0, bit 31 and neighbouring bits differ. It then compares the word and the carry separately against a wide-arithmetic reference model. Rotate through carry is driven with both carry polarities and several distances, to show that the carry-in enters bit 31 and that the distance has no effect.

// File: rtl/bshf_pkg.sv
package bshf_pkg;

    typedef enum logic [2:0] {
        KIND_LEFT   = 3'd0,
        KIND_RIGHT  = 3'd1,
        KIND_ARITH  = 3'd2,
        KIND_ROTATE = 3'd3,
        KIND_EXTEND = 3'd4,
        KIND_RSV5   = 3'd5,
        KIND_RSV6   = 3'd6,
        KIND_RSV7   = 3'd7
    } shift_kind_e;

endpackage

// File: rtl/bshf_rotator.sv
module bshf_rotator #(
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] word_in,
    input  logic [IDX_W-1:0] rot_amt,
    output logic [WIDTH-1:0] word_out
);

    logic [WIDTH-1:0] stage [0:IDX_W];

    assign stage[0] = word_in;

    for (genvar s = 0; s < IDX_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = rot_amt[s]
            ? {stage[s][STEP-1:0], stage[s][WIDTH-1:STEP]}
            : stage[s];
    end

    assign word_out = stage[IDX_W];

    always_comb begin
        AST_ROT_KEEPS_ONES: assert ($countones(word_out) == $countones(word_in)); // R7
    end

endmodule

// File: rtl/bshf_fill_mask.sv
module bshf_fill_mask #(
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(WIDTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic [CNT_W-1:0] fill_cnt,
    output logic [WIDTH-1:0] hi_mask,
    output logic [WIDTH-1:0] lo_mask
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign hi_mask[i]           = (fill_cnt >= CNT_W'(WIDTH - i));
        assign lo_mask[WIDTH-1-i]   = hi_mask[i];
    end

    always_comb begin
        AST_MASK_WEIGHT: assert ($countones(hi_mask) == int'(fill_cnt)); // R5
        AST_MASK_TOP: assert ((fill_cnt == '0) || hi_mask[WIDTH-1]); // R5
    end

endmodule

// File: rtl/bshf_top.sv
module bshf_top
    import bshf_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic [2:0]       shift_kind,
    input  logic [AMT_W-1:0] shift_dist,
    input  logic             carry_in,
    output logic [WIDTH-1:0] data_out,
    output logic             carry_out
);

    localparam int IDX_W = $clog2(WIDTH);
    localparam int CNT_W = IDX_W + 1;
    localparam logic [AMT_W-1:0] DIST_FULL = AMT_W'(WIDTH);

    shift_kind_e      kind;
    logic             dist_zero;
    logic             dist_over;
    logic [IDX_W-1:0] dist_lo;
    logic [IDX_W-1:0] rot_amt;
    logic [IDX_W-1:0] left_carry_idx;
    logic [IDX_W-1:0] right_carry_idx;
    logic [CNT_W-1:0] fill_cnt;
    logic [WIDTH-1:0] rotated;
    logic [WIDTH-1:0] hi_mask;
    logic [WIDTH-1:0] lo_mask;
    logic             sign_bit;

    assign kind            = shift_kind_e'(shift_kind);
    assign dist_zero       = (shift_dist == '0);
    assign dist_over       = (shift_dist > DIST_FULL);
    assign dist_lo         = shift_dist[IDX_W-1:0];
    assign left_carry_idx  = IDX_W'(0) - dist_lo;
    assign right_carry_idx = dist_lo - IDX_W'(1);
    assign sign_bit        = data_in[WIDTH-1];
    assign fill_cnt        = dist_over ? CNT_W'(WIDTH) : shift_dist[CNT_W-1:0];

    // rotation distance chosen per kind
    always_comb begin
        unique case (kind)
            KIND_LEFT:   rot_amt = left_carry_idx;
            KIND_EXTEND: rot_amt = IDX_W'(1);
            default:     rot_amt = dist_lo;
        endcase
    end

    bshf_rotator #(.WIDTH(WIDTH)) rot_i (
        .word_in  (data_in),
        .rot_amt  (rot_amt),
        .word_out (rotated)
    );

    bshf_fill_mask #(.WIDTH(WIDTH)) mask_i (
        .fill_cnt (fill_cnt),
        .hi_mask  (hi_mask),
        .lo_mask  (lo_mask)
    );

    // per-kind output selection
    always_comb begin
        data_out  = data_in;
        carry_out = carry_in;
        unique case (kind)
            KIND_LEFT: begin
                if (dist_over) begin
                    data_out  = '0;
                    carry_out = 1'b0;
                end else if (!dist_zero) begin
                    data_out  = rotated & ~lo_mask;
                    carry_out = data_in[left_carry_idx];
                end
            end
            KIND_RIGHT: begin
                if (dist_over) begin
                    data_out  = '0;
                    carry_out = 1'b0;
                end else if (!dist_zero) begin
                    data_out  = rotated & ~hi_mask;
                    carry_out = data_in[right_carry_idx];
                end
            end
            KIND_ARITH: begin
                if (!dist_zero) begin
                    data_out  = (rotated & ~hi_mask) | (hi_mask & {WIDTH{sign_bit}});
                    carry_out = dist_over ? sign_bit : data_in[right_carry_idx];
                end
            end
            KIND_ROTATE: begin
                if (!dist_zero) begin
                    data_out  = rotated;
                    carry_out = rotated[WIDTH-1];
                end
            end
            KIND_EXTEND: begin
                data_out  = {carry_in, rotated[WIDTH-2:0]};
                carry_out = data_in[0];
            end
            KIND_RSV5, KIND_RSV6, KIND_RSV7: begin
                data_out  = data_in;
                carry_out = carry_in;
            end
        endcase
    end

    always_comb begin
        AST_ZERO_DIST_PASS: assert (!(dist_zero && shift_kind < 3'd4) ||
                                    (data_out == data_in && carry_out == carry_in)); // R2
        AST_RSV_PASS: assert (shift_kind < 3'd5 ||
                              (data_out == data_in && carry_out == carry_in)); // R1
        AST_OVER_LOGICAL_ZERO: assert (!(dist_over && shift_kind < 3'd2) ||
                                       (data_out == '0 && !carry_out)); // R8
        AST_OVER_ARITH_SIGN: assert (!(dist_over && shift_kind == 3'd2) ||
                                     (data_out == {WIDTH{sign_bit}} && carry_out == sign_bit)); // R6
        AST_ROT_CARRY_TOP: assert (!(shift_kind == 3'd3 && !dist_zero) ||
                                   carry_out == data_out[WIDTH-1]); // R7
        AST_EXTEND_CARRY: assert (shift_kind != 3'd4 ||
                                  (carry_out == data_in[0] && data_out[WIDTH-1] == carry_in)); // R9
    end

endmodule

// File: tb/bshf_top_tb_top.sv
module bshf_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] data_in = '0;
    logic [2:0]  shift_kind = '0;
    logic [7:0]  shift_dist = '0;
    logic        carry_in = 1'b0;
    logic [31:0] data_out;
    logic        carry_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    bshf_top dut_i (
        .data_in    (data_in),
        .shift_kind (shift_kind),
        .shift_dist (shift_dist),
        .carry_in   (carry_in),
        .data_out   (data_out),
        .carry_out  (carry_out)
    );

    // independent reference built on wide arithmetic
    function automatic logic [32:0] ref_model(input logic [2:0] k, input logic [7:0] d,
                                              input logic [31:0] x, input logic c);
        logic [63:0] w;
        logic [31:0] r;
        logic        co;
        int          m;
        r  = x;
        co = c;
        case (k)
            3'd0: if (d > 32) begin r = 0; co = 0; end
                  else if (d != 0) begin w = {32'b0, x} << d; r = w[31:0]; co = w[32]; end
            3'd1: if (d > 32) begin r = 0; co = 0; end
                  else if (d != 0) begin w = {x, 32'b0} >> d; r = w[63:32]; co = w[31]; end
            3'd2: if (d > 32) begin r = {32{x[31]}}; co = x[31]; end
                  else if (d != 0) begin
                      w = $signed({x, 32'b0}) >>> d; r = w[63:32]; co = w[31];
                  end
            3'd3: if (d != 0) begin
                      m = int'(d) % 32; w = {x, x} >> m; r = w[31:0]; co = r[31];
                  end
            3'd4: begin r = {c, x[31:1]}; co = x[0]; end
            default: ;
        endcase
        return {co, r};
    endfunction

    task automatic apply(input string tag, input logic [2:0] k, input logic [7:0] d,
                         input logic [31:0] x, input logic c);
        logic [32:0] exp;
        @(negedge clk);
        shift_kind = k; shift_dist = d; data_in = x; carry_in = c;
        #2;
        exp = ref_model(k, d, x, c);
        n_vec++;
        if (data_out !== exp[31:0] || carry_out !== exp[32]) begin
            n_bad++;
            $display("FAIL %s kind=%0d dist=%0d op=%h cin=%b: got %h/%b expected %h/%b",
                     tag, k, d, x, c, data_out, carry_out, exp[31:0], exp[32]);
        end
    endtask

    task automatic t_idle_state;
        apply("R2", 3'd0, 8'd0, 32'h0, 1'b0);
        if (data_out !== 32'h0 || carry_out !== 1'b0) begin
            n_bad++;
            $display("FAIL R2 idle state: got %h/%b expected 00000000/0", data_out, carry_out);
        end
    endtask

    task automatic t_zero_dist;
        for (int k = 0; k < 4; k++) begin
            apply("R2", 3'(k), 8'd0, 32'hA5C3_0F81, 1'b1);
            apply("R2", 3'(k), 8'd0, 32'h7E00_0002, 1'b0);
        end
    endtask

    task automatic t_left;
        int ds[7] = '{1, 2, 7, 16, 31, 32, 30};
        foreach (ds[i]) begin
            apply("R3", 3'd0, 8'(ds[i]), 32'h8000_0001, 1'b0);
            apply("R3", 3'd0, 8'(ds[i]), 32'h5A5A_F00D, 1'b1);
        end
    endtask

    task automatic t_right;
        int ds[6] = '{1, 2, 15, 31, 32, 9};
        foreach (ds[i]) begin
            apply("R4", 3'd1, 8'(ds[i]), 32'h8000_0001, 1'b0);
            apply("R4", 3'd1, 8'(ds[i]), 32'hC0DE_1234, 1'b1);
        end
    endtask

    task automatic t_arith;
        int ds[6] = '{1, 4, 16, 31, 32, 5};
        foreach (ds[i]) begin
            apply("R5", 3'd2, 8'(ds[i]), 32'h8000_0001, 1'b0);
            apply("R5", 3'd2, 8'(ds[i]), 32'h7FFF_FFFE, 1'b1);
        end
    endtask

    task automatic t_arith_over;
        apply("R6", 3'd2, 8'd33,  32'h8000_0000, 1'b0);
        apply("R6", 3'd2, 8'd33,  32'h7FFF_FFFF, 1'b1);
        apply("R6", 3'd2, 8'd255, 32'hF000_0000, 1'b0);
        apply("R6", 3'd2, 8'd100, 32'h0123_4567, 1'b1);
    endtask

    task automatic t_rotate;
        int ds[9] = '{1, 4, 31, 32, 33, 64, 96, 224, 255};
        foreach (ds[i]) begin
            apply("R7", 3'd3, 8'(ds[i]), 32'h8000_0001, 1'b0);
            apply("R7", 3'd3, 8'(ds[i]), 32'h1234_5678, 1'b1);
        end
    endtask

    task automatic t_logical_over;
        for (int k = 0; k < 2; k++) begin
            apply("R8", 3'(k), 8'd33,  32'hFFFF_FFFF, 1'b1);
            apply("R8", 3'(k), 8'd200, 32'h8000_0001, 1'b1);
            apply("R8", 3'(k), 8'd255, 32'hDEAD_BEEF, 1'b0);
        end
    endtask

    task automatic t_extend;
        int ds[4] = '{0, 1, 32, 255};
        foreach (ds[i]) begin
            apply("R9", 3'd4, 8'(ds[i]), 32'h0000_0001, 1'b1);
            apply("R9", 3'd4, 8'(ds[i]), 32'hF0F0_F0F2, 1'b0);
        end
    endtask

    task automatic t_reserved;
        for (int k = 5; k < 8; k++) begin
            apply("R1", 3'(k), 8'd4,  32'h1357_9BDF, 1'b1);
            apply("R1", 3'(k), 8'd40, 32'h8642_0ACE, 1'b0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle_state();
        t_zero_dist();
        t_left();
        t_right();
        t_arith();
        t_arith_over();
        t_rotate();
        t_logical_over();
        t_extend();
        t_reserved();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule